// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block watches a small set of level-sensitive interrupt lines and turns each new assertion of an enabled line into a single 32-bit memory write. The write goes to one of two programmable targets, and a per-line routing bit picks which one. The target register supplies both halves of the message. Its upper bits, with the low five cleared, form the write address. Its low five bits form the write data. The block's memory port can therefore carry both an address and a small code without any extra registers.

A word-addressed register port holds the enable mask, the routing bits and the two targets. The same port shows the live level of each line, a sticky record of new assertions, and the routed-and-enabled requests for each target. Reading or writing the sticky record empties it. When several lines come up in the same cycle, their messages wait in a per-line request vector. They leave one at a time over a valid/ready handshake, lowest line number first. In the default configuration of eleven lines, line 0 to 5 are shared-bus interrupts A to F, 6 is an external interrupt, 7 is a non-fatal bus error, 8 is a PS/2 port, 9 is unused and 10 is a serial port.

Top module: `msi_irq_ctrl`

## Requirements
- R1: Each bit of the level register equals the matching `irq_in` bit sampled at the previous rising clock edge.
- R2: A line that is high while its level bit is 0 sets its bit in the sticky record register.
- R3: Any read or any write of the sticky record register clears it at the end of that cycle. A new assertion in the same cycle still sets its bit.
- R4: A new assertion of a line whose mask bit is 1 produces exactly one message. A line whose mask bit is 0 produces none.
- R5: A message uses target 1 when the line's routing bit is 1 and target 0 otherwise.
- R6: The message address is the selected target with bits [4:0] forced to 0. The message data is target bits [4:0], zero-extended.
- R7: Routed view 0 reads level & mask & ~route. Routed view 1 reads level & mask & route.
- R8: Writes to the level register and to both routed views change nothing.
- R9: After reset, both targets read 0xFFFB0003, the mask, routing and sticky record read 0, and `msg_valid` is low.
- R10: Messages pending at the same time leave one per handshake, lowest line first. While `msg_valid` is high and `msg_ready` is low, the address and data stay unchanged.
- R11: The register word map is: 0 level, 1 mask, 2 routing, 3 sticky record, 4 target 0, 5 target 1, 6 view 0, 7 view 1. Words 8 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| irq_in | input | N_SRC | Level-sensitive interrupt lines |
| reg_rd | input | 1 | Register read strobe; data is valid in the same cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| msg_valid | output | 1 | A message write is offered |
| msg_ready | input | 1 | The memory side accepts the offered message |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions check on every cycle the behaviour that needs no stimulus history. The level readback lags the input by one edge, and a message holds steady while it is stalled. The message address stays aligned with its data confined to five bits, and the sticky record is empty after an access unless a line rose in the same cycle. Only the bench scenarios can show the rest. These are the target choice made by routing, the silence of masked lines, and the strict lowest-first order of a burst of messages. They also cover the arithmetic of the routed views over many patterns and the write-immunity of the read-only words.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int LOW_BITS = 5;

  localparam logic [AW-1:0] A_LEVEL = 4'd0;
  localparam logic [AW-1:0] A_MASK  = 4'd1;
  localparam logic [AW-1:0] A_ROUTE = 4'd2;
  localparam logic [AW-1:0] A_STICK = 4'd3;
  localparam logic [AW-1:0] A_TGT0  = 4'd4;
  localparam logic [AW-1:0] A_TGT1  = 4'd5;
  localparam logic [AW-1:0] A_VIEW0 = 4'd6;
  localparam logic [AW-1:0] A_VIEW1 = 4'd7;

  localparam logic [DW-1:0] TGT_RESET = 32'hFFFB_0003;
endpackage

// File: rtl/msi_src_track.sv
module msi_src_track #(
  parameter int N_SRC = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             stick_clr,
  output logic [N_SRC-1:0] level_o,
  output logic [N_SRC-1:0] stick_o,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] level_q, level_n;
  logic [N_SRC-1:0] stick_q, stick_n;

  always_comb begin
    rise_o  = irq_in & ~level_q;
    level_n = irq_in;
    stick_n = (stick_clr ? '0 : stick_q) | rise_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      stick_q <= '0;
    end else begin
      level_q <= level_n;
      stick_q <= stick_n;
    end
  end

  assign level_o = level_q;
  assign stick_o = stick_q;
endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_irq_pkg::*;
#(
  parameter int N_SRC = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] route_o,
  output logic [DW-1:0]    tgt0_o,
  output logic [DW-1:0]    tgt1_o
);
  logic [N_SRC-1:0] mask_q, mask_n, route_q, route_n;
  logic [DW-1:0]    tgt0_q, tgt0_n, tgt1_q, tgt1_n;

  always_comb begin
    mask_n  = mask_q;
    route_n = route_q;
    tgt0_n  = tgt0_q;
    tgt1_n  = tgt1_q;
    if (wr_en) begin
      case (addr)
        A_MASK:  mask_n  = wdata[N_SRC-1:0];
        A_ROUTE: route_n = wdata[N_SRC-1:0];
        A_TGT0:  tgt0_n  = wdata;
        A_TGT1:  tgt1_n  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
      tgt0_q  <= TGT_RESET;
      tgt1_q  <= TGT_RESET;
    end else begin
      mask_q  <= mask_n;
      route_q <= route_n;
      tgt0_q  <= tgt0_n;
      tgt1_q  <= tgt1_n;
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;
  assign tgt0_o  = tgt0_q;
  assign tgt1_o  = tgt1_q;
endmodule

// File: rtl/msi_msg_issue.sv
module msi_msg_issue
  import msi_irq_pkg::*;
#(
  parameter int N_SRC = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] new_req,
  input  logic [N_SRC-1:0] route,
  input  logic [DW-1:0]    tgt0,
  input  logic [DW-1:0]    tgt1,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [DW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << LOW_BITS) - 1);

  logic [N_SRC-1:0] wait_q, wait_n;
  logic             vld_q, vld_n;
  logic [DW-1:0]    addr_q, addr_n, data_q, data_n;
  logic             found;
  logic [IW-1:0]    pick;
  logic             load;
  logic [DW-1:0]    sel;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (wait_q[i]) begin
        found = 1'b1;
        pick  = IW'(i);
      end
    end
  end

  always_comb begin
    load   = found && (!vld_q || msg_ready);
    sel    = route[pick] ? tgt1 : tgt0;
    wait_n = wait_q;
    if (load) wait_n[pick] = 1'b0;
    wait_n = wait_n | new_req;
    vld_n  = vld_q;
    addr_n = addr_q;
    data_n = data_q;
    if (load) begin
      vld_n  = 1'b1;
      addr_n = sel & ~LOW_MASK;
      data_n = sel & LOW_MASK;
    end else if (msg_ready) begin
      vld_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wait_q <= wait_n;
      vld_q  <= vld_n;
      if (load) begin
        addr_q <= addr_n;
        data_q <= data_n;
      end
    end
  end

  assign msg_valid = vld_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_irq_pkg::*;
#(
  parameter int N_SRC = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [DW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [N_SRC-1:0] level_w, stick_w, rise_w, mask_w, route_w;
  logic [DW-1:0]    tgt0_w, tgt1_w;
  logic             stick_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign stick_clr = (reg_rd || reg_wr) && (reg_addr == A_STICK);

  msi_src_track #(.N_SRC(N_SRC)) u_track (
    .clk(clk), .rst_n(rst_n_s), .irq_in(irq_in), .stick_clr(stick_clr),
    .level_o(level_w), .stick_o(stick_w), .rise_o(rise_w)
  );

  msi_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .mask_o(mask_w), .route_o(route_w),
    .tgt0_o(tgt0_w), .tgt1_o(tgt1_w)
  );

  msi_msg_issue #(.N_SRC(N_SRC)) u_issue (
    .clk(clk), .rst_n(rst_n_s), .new_req(rise_w & mask_w), .route(route_w),
    .tgt0(tgt0_w), .tgt1(tgt1_w), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_comb begin
    case (reg_addr)
      A_LEVEL: reg_rdata = DW'(level_w);
      A_MASK:  reg_rdata = DW'(mask_w);
      A_ROUTE: reg_rdata = DW'(route_w);
      A_STICK: reg_rdata = DW'(stick_w);
      A_TGT0:  reg_rdata = tgt0_w;
      A_TGT1:  reg_rdata = tgt1_w;
      A_VIEW0: reg_rdata = DW'(level_w & mask_w & ~route_w);
      A_VIEW1: reg_rdata = DW'(level_w & mask_w & route_w);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_irq_ctrl_chk.sv
module msi_irq_ctrl_chk
  import msi_irq_pkg::*;
#(
  parameter int N_SRC = 11
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic [N_SRC-1:0] irq_in,
  input logic [N_SRC-1:0] stick_q,
  input logic [N_SRC-1:0] rise,
  input logic             stick_clr,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_rdata,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [DW-1:0]    msg_addr,
  input logic [DW-1:0]    msg_data
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) armed_q <= 1'b0;
    else          armed_q <= 1'b1;
  end

  // R1
  a_r1_level_lag: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed_q && reg_rd && reg_addr == A_LEVEL) |-> reg_rdata[N_SRC-1:0] == $past(irq_in));

  // R3
  a_r3_stick_cleared: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed_q && stick_clr) |=> (stick_q & ~$past(rise)) == '0);

  // R6
  a_r6_msg_layout: assert property (@(posedge clk) disable iff (!rst_n_s)
    msg_valid |-> (msg_addr[LOW_BITS-1:0] == '0 && msg_data[DW-1:LOW_BITS] == '0));

  // R10
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R9
  a_r9_idle_in_reset: assert property (@(posedge clk) !rst_n_s |-> !msg_valid);
endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .irq_in(irq_in), .stick_q(stick_w),
  .rise(rise_w), .stick_clr(stick_clr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msi_irq_ctrl_test.sv
module msi_irq_ctrl_test;
  localparam int N = 11;
  localparam logic [31:0] ALL = 32'h7FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] log_a [0:31];
  logic [31:0] log_d [0:31];
  int log_cnt = 0;

  always #5 clk = ~clk;

  msi_irq_ctrl #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  always @(posedge clk) begin
    if (msg_valid && msg_ready && log_cnt < 32) begin
      log_a[log_cnt] = msg_addr;
      log_d[log_cnt] = msg_data;
      log_cnt = log_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, t0, t1, te, lv, mk, rt;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R9 reset state
    rd(4'd4, v); chk("R9 target0", v, 32'hFFFB_0003);
    rd(4'd5, v); chk("R9 target1", v, 32'hFFFB_0003);
    rd(4'd1, v); chk("R9 mask", v, 0);
    rd(4'd2, v); chk("R9 route", v, 0);
    rd(4'd3, v); chk("R9 sticky", v, 0);
    chk("R9 msg_valid", 32'(msg_valid), 0);
    // R11 unmapped words
    for (int a = 8; a < 16; a++) begin
      rd(4'(a), v); chk("R11 unmapped", v, 0);
    end

    // Per-line sweep: R1 R2 R4 R5 R6
    for (int s = 0; s < N; s++) begin
      t0 = 32'h5000_0000 | (s << 8) | (s + 1);
      t1 = 32'hA000_0000 | (s << 12) | (31 - s);
      wr(4'd4, t0); wr(4'd5, t1);
      wr(4'd2, (s % 2) ? (32'd1 << s) : 32'd0);
      wr(4'd1, 32'd1 << s);
      log_cnt = 0;
      irq_in = N'(1 << s);
      idle(2);
      rd(4'd0, v); chk("R1 level high", v, 32'd1 << s);
      idle(3);
      irq_in = '0;
      idle(2);
      rd(4'd0, v); chk("R1 level low", v, 0);
      chk("R4 one message", 32'(log_cnt), 1);
      te = (s % 2) ? t1 : t0;
      chk("R5 R6 address", log_a[0], te & ~32'h1F);
      chk("R5 R6 data", log_d[0], te & 32'h1F);
      rd(4'd3, v); chk("R2 sticky bit", v, 32'd1 << s);
      rd(4'd3, v); chk("R3 cleared by read", v, 0);
    end

    // Masked line: R4, R2, R3 write clear
    wr(4'd1, 0);
    log_cnt = 0;
    irq_in = N'(11'h008); idle(3); irq_in = '0; idle(4);
    chk("R4 masked silent", 32'(log_cnt), 0);
    rd(4'd3, v); chk("R2 masked sticky", v, 32'h8);
    irq_in = N'(11'h010); idle(3); irq_in = '0; idle(2);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, v); chk("R3 cleared by write", v, 0);

    // R3 rise in the same cycle as a sticky read
    reg_rd = 1'b1; reg_addr = 4'd3; irq_in = N'(11'h040);
    #1 chk("R3 old value", reg_rdata, 0);
    @(negedge clk); reg_rd = 1'b0;
    rd(4'd3, v); chk("R3 rise survives clear", v, 32'h40);
    irq_in = '0; idle(2);
    rd(4'd3, v);

    // Routed views over patterns: R7
    for (int p = 0; p < 12; p++) begin
      lv = (p * 32'h2C5 + 32'h101) & ALL;
      mk = (p * 32'h1B3 + 32'h55) & ALL;
      rt = ((p * 32'h3A1) ^ 32'h2AA) & ALL;
      wr(4'd1, mk); wr(4'd2, rt);
      irq_in = N'(lv); idle(2);
      rd(4'd6, v); chk("R7 view0", v, lv & mk & ~rt);
      rd(4'd7, v); chk("R7 view1", v, lv & mk & rt);
      irq_in = '0; idle(2);
    end
    idle(20);

    // R8 read-only words
    wr(4'd1, ALL); wr(4'd2, 32'h0F0);
    irq_in = N'(11'h123); idle(2);
    wr(4'd0, ALL); wr(4'd6, 32'h0); wr(4'd7, ALL);
    rd(4'd0, v); chk("R8 level untouched", v, 32'h123);
    rd(4'd6, v); chk("R8 view0 untouched", v, 32'h123 & ~32'h0F0);
    rd(4'd7, v); chk("R8 view1 untouched", v, 32'h123 & 32'h0F0);
    irq_in = '0; idle(20);

    // R10 burst: lines 0,2,5,7 together; 2 and 7 routed to target 1
    wr(4'd2, 32'h084);
    wr(4'd4, 32'h1111_1101); wr(4'd5, 32'h2222_2202);
    msg_ready = 1'b0; log_cnt = 0;
    irq_in = N'(11'h0A5); idle(4);
    chk("R10 offered", 32'(msg_valid), 1);
    chk("R10 first is line 0", msg_addr, 32'h1111_1100);
    idle(3);
    chk("R10 held addr", msg_addr, 32'h1111_1100);
    chk("R10 held data", msg_data, 32'h1);
    msg_ready = 1'b1; idle(8);
    chk("R10 count", 32'(log_cnt), 4);
    chk("R10 order 0", log_a[0], 32'h1111_1100);
    chk("R10 order 2", log_a[1], 32'h2222_2200);
    chk("R10 order 5", log_a[2], 32'h1111_1100);
    chk("R10 order 7", log_d[3], 32'h2);
    irq_in = '0; idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule